// File: doc/BRIEF.md
# SPI Memory Page Write Sequencer

This block writes up to one page of bytes to an SPI serial EEPROM or flash without holding up the requester. A request carries a start address and a byte count minus one. It also carries the most recent value of the memory's status register. Within one cycle the block judges the request and answers with a result code. A refused request produces no traffic on the serial bus. An accepted request frees the requester at once, and the block then runs the whole transfer in the background.

The block does not shift bits itself. It hands one byte at a time to an external SPI byte shifter and moves on when that shifter reports the byte complete. For each accepted write it sends two frames. The first is a single write-enable byte. The second holds the write opcode, the address bytes (most significant first) and the data bytes. It fetches the data bytes one at a time through an index port. The idle flag shows that the serial bus is free again. It does not show that the memory has finished programming, so the memory's own ready bit still has to be polled.

Top module: `spi_page_writer`

## Requirements
- R1: After reset, csN is 1, idle is 1, txStart is 0 and respValid is 0.
- R2: Each cycle with reqValid at 1 is answered one clock later by respValid at 1 with respCode: 0 accepted, 1 busy, 2 out of range, 3 write protected.
- R3: The checks run in this priority. A request while idle is 0 gets code 1. Then a last byte address (reqAddr + reqLastIdx) above MEM_BYTES-1 gets code 2. Then statusIn bit 0 at 1 (device busy) gets code 1. Then a protected range gets code 3.
- R4: statusIn bits 3:2 select the protected area. 0 protects nothing. 1 protects addresses from 3/4 of MEM_BYTES upward. 2 protects from 1/2 upward. 3 protects the whole array. A request is protected when its last byte address falls in that area.
- R5: A refused request starts no byte, keeps csN at 1 and leaves idle at 1.
- R6: An accepted request first sends a one-byte frame holding 0x06. csN rises when that byte completes and stays high for one cycle before the next frame.
- R7: The second frame holds 0x02, then ADDR_BYTES address bytes most significant first, then reqLastIdx+1 data bytes. Data byte k is the value presented on srcData while srcIdx equals k.
- R8: txStart is a one-cycle pulse, given only while csN is 0. After the first byte, the next byte starts only in the cycle after a txDone. csN rises and idle returns only after the last data byte's txDone.
- R9: A reqLastIdx of PAGE_BYTES-1 writes a full page of PAGE_BYTES data bytes in one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request strobe |
| reqAddr | input | 8*ADDR_BYTES | Start address in the memory |
| reqLastIdx | input | log2(PAGE_BYTES) | Number of data bytes minus one |
| statusIn | input | 8 | Last read device status (bit 0 busy, bits 3:2 protect select) |
| respValid | output | 1 | Result valid, one cycle after the request |
| respCode | output | 2 | Result code |
| idle | output | 1 | No transfer in progress on the serial bus |
| csN | output | 1 | Memory chip select, active low |
| txStart | output | 1 | Start shifting txByte |
| txByte | output | 8 | Byte handed to the shifter |
| txDone | input | 1 | Shifter finished the current byte |
| srcIdx | output | log2(PAGE_BYTES) | Index of the data byte wanted |
| srcData | input | 8 | Data byte at srcIdx |

## Verification
A wrong phase or count shows up on the byte stream within one byte time. If the phase is wrong, an address byte comes out where a data byte belongs, or the opcode is missing. If the count is off by one, the frame ends one byte early or late, so csN rises at the wrong byte. A check that judges wrongly shows in the result code one cycle after the request. It also shows in whether any byte starts at all. Refused requests are followed by a quiet window in which no txStart and no csN edge may appear.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    RESP_OK    = 2'd0,
    RESP_BUSY  = 2'd1,
    RESP_RANGE = 2'd2,
    RESP_PROT  = 2'd3
  } respCode_e;

  typedef enum logic [2:0] {
    ST_READY, ST_WREN, ST_GAP, ST_INSTR, ST_ADDR, ST_DATA
  } pwState_e;

  typedef struct packed {
    logic capture;
    logic sendWren;
    logic sendOpcode;
    logic sendFirstAddr;
    logic sendNextAddr;
    logic sendFirstData;
    logic sendNextData;
  } pwStrobe_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
endpackage

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int MEM_BYTES  = 32768,
  parameter int PAGE_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pwStrobe_t                     strobe,
  input  logic [8*ADDR_BYTES-1:0]       reqAddr,
  input  logic [$clog2(PAGE_BYTES)-1:0] reqLastIdx,
  input  logic [7:0]                    statusIn,
  input  logic [7:0]                    srcData,
  output respCode_e                     chkCode,
  output logic                          addrDone,
  output logic                          dataDone,
  output logic [$clog2(PAGE_BYTES)-1:0] srcIdx,
  output logic [7:0]                    txByte
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int CNT_W  = $clog2(PAGE_BYTES);
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [ADDR_W:0] MEM_LAST  = (ADDR_W+1)'(MEM_BYTES - 1);
  localparam logic [ADDR_W:0] BASE_Q3   = (ADDR_W+1)'((MEM_BYTES / 4) * 3);
  localparam logic [ADDR_W:0] BASE_HALF = (ADDR_W+1)'(MEM_BYTES / 2);

  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  lastIdxReg;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        addrBytes [ADDR_BYTES];
  logic [ADDR_W:0]   lastAddr;
  logic              inProt;

  // address bytes, most significant first
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addrByte
    assign addrBytes[g] = addrReg[8*(ADDR_BYTES-1-g) +: 8];
  end

  // request checks
  always_comb begin
    lastAddr = {1'b0, reqAddr} + (ADDR_W+1)'(reqLastIdx);
    unique case (statusIn[3:2])
      2'd0:    inProt = 1'b0;
      2'd1:    inProt = (lastAddr >= BASE_Q3);
      2'd2:    inProt = (lastAddr >= BASE_HALF);
      default: inProt = 1'b1;
    endcase
    if (lastAddr > MEM_LAST)  chkCode = RESP_RANGE;
    else if (statusIn[0])     chkCode = RESP_BUSY;
    else if (inProt)          chkCode = RESP_PROT;
    else                      chkCode = RESP_OK;
  end

  assign addrDone = (cnt == CNT_W'(ADDR_BYTES));
  assign dataDone = (cnt == lastIdxReg);
  assign srcIdx   = strobe.sendNextData ? cnt + CNT_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg    <= '0;
      lastIdxReg <= '0;
      cnt        <= '0;
      txByte     <= '0;
    end else begin
      if (strobe.capture) begin
        addrReg    <= reqAddr;
        lastIdxReg <= reqLastIdx;
      end
      if (strobe.sendWren)   txByte <= OP_WREN;
      if (strobe.sendOpcode) txByte <= OP_WRITE;
      if (strobe.sendFirstAddr) begin
        txByte <= addrBytes[0];
        cnt    <= CNT_W'(1);
      end
      if (strobe.sendNextAddr) begin
        txByte <= addrBytes[cnt[IDX_W-1:0]];
        cnt    <= cnt + CNT_W'(1);
      end
      if (strobe.sendFirstData) begin
        txByte <= srcData;
        cnt    <= '0;
      end
      if (strobe.sendNextData) begin
        txByte <= srcData;
        cnt    <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  respCode_e  chkCode,
  input  logic       txDone,
  input  logic       addrDone,
  input  logic       dataDone,
  output pwStrobe_t  strobe,
  output logic       csN,
  output logic       txStart,
  output logic       respValid,
  output respCode_e  respCode,
  output logic       idle
);
  pwState_e state;
  logic     accept;

  assign idle   = (state == ST_READY);
  assign accept = reqValid && idle && (chkCode == RESP_OK);

  always_comb begin
    strobe               = '0;
    strobe.capture       = accept;
    strobe.sendWren      = accept;
    strobe.sendOpcode    = (state == ST_GAP);
    strobe.sendFirstAddr = (state == ST_INSTR) && txDone;
    strobe.sendNextAddr  = (state == ST_ADDR) && txDone && !addrDone;
    strobe.sendFirstData = (state == ST_ADDR) && txDone && addrDone;
    strobe.sendNextData  = (state == ST_DATA) && txDone && !dataDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_READY;
      csN       <= 1'b1;
      txStart   <= 1'b0;
      respValid <= 1'b0;
      respCode  <= RESP_OK;
    end else begin
      respValid <= reqValid;
      respCode  <= idle ? chkCode : RESP_BUSY;
      txStart   <= strobe.sendWren | strobe.sendOpcode | strobe.sendFirstAddr |
                   strobe.sendNextAddr | strobe.sendFirstData | strobe.sendNextData;
      unique case (state)
        ST_READY: if (accept) begin
          state <= ST_WREN;
          csN   <= 1'b0;
        end
        ST_WREN: if (txDone) begin
          state <= ST_GAP;
          csN   <= 1'b1;
        end
        ST_GAP: begin
          state <= ST_INSTR;
          csN   <= 1'b0;
        end
        ST_INSTR: if (txDone) state <= ST_ADDR;
        ST_ADDR:  if (txDone && addrDone) state <= ST_DATA;
        ST_DATA: if (txDone && dataDone) begin
          state <= ST_READY;
          csN   <= 1'b1;
        end
        default: state <= ST_READY;
      endcase
    end
  end
endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer
  import pw_pkg::*;
#(
  parameter int ADDR_BYTES = 2,
  parameter int MEM_BYTES  = 32768,
  parameter int PAGE_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [8*ADDR_BYTES-1:0]       reqAddr,
  input  logic [$clog2(PAGE_BYTES)-1:0] reqLastIdx,
  input  logic [7:0]                    statusIn,
  output logic                          respValid,
  output logic [1:0]                    respCode,
  output logic                          idle,
  output logic                          csN,
  output logic                          txStart,
  output logic [7:0]                    txByte,
  input  logic                          txDone,
  output logic [$clog2(PAGE_BYTES)-1:0] srcIdx,
  input  logic [7:0]                    srcData
);
  pwStrobe_t strobe;
  respCode_e chkCode;
  respCode_e respCodeE;
  logic      addrDone;
  logic      dataDone;

  assign respCode = respCodeE;

  pw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .chkCode(chkCode),
    .txDone(txDone), .addrDone(addrDone), .dataDone(dataDone),
    .strobe(strobe), .csN(csN), .txStart(txStart),
    .respValid(respValid), .respCode(respCodeE), .idle(idle)
  );

  pw_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqLastIdx(reqLastIdx), .statusIn(statusIn), .srcData(srcData),
    .chkCode(chkCode), .addrDone(addrDone), .dataDone(dataDone),
    .srcIdx(srcIdx), .txByte(txByte)
  );
endmodule

// File: rtl/spi_page_writer_chk.sv
module spi_page_writer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       respValid,
  input logic [1:0] respCode,
  input logic       idle,
  input logic       csN,
  input logic       txStart,
  input logic       txDone
);
  // R8
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> csN);

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  // R3
  refuse_when_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !idle) |=> (respCode == 2'd1));

  // R8
  start_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !csN);

  // R8
  start_is_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  // R6
  cs_rise_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> $past(txDone));

  // R5
  reject_stays_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && idle) |=> ((respCode != 2'd0) |-> (idle && csN && !txStart)));
endmodule

bind spi_page_writer spi_page_writer_chk u_chk (.*);

// File: tb/spi_page_writer_bench.sv
`timescale 1ns/1ps
module spi_page_writer_bench;
  localparam int ADDR_BYTES = 2;
  localparam int MEM_BYTES  = 32768;
  localparam int PAGE_BYTES = 256;
  localparam int NV = 12;

  // {addr[15:0], lastIdx[7:0], status[7:0], expCode[1:0]}
  localparam logic [33:0] VEC [NV] = '{
    {16'h0100, 8'd3,   8'h00, 2'd0},
    {16'h7FFE, 8'd1,   8'h00, 2'd0},
    {16'h7FFE, 8'd2,   8'h00, 2'd2},
    {16'h1000, 8'd0,   8'h01, 2'd1},
    {16'h6000, 8'd0,   8'h04, 2'd3},
    {16'h5FFF, 8'd0,   8'h04, 2'd0},
    {16'h5FF0, 8'd16,  8'h04, 2'd3},
    {16'h4000, 8'd0,   8'h08, 2'd3},
    {16'h3FFF, 8'd0,   8'h08, 2'd0},
    {16'h0000, 8'd0,   8'h0C, 2'd3},
    {16'h7FFF, 8'd1,   8'h01, 2'd2},
    {16'h0000, 8'd255, 8'h00, 2'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqLastIdx = '0;
  logic [7:0] statusIn = '0;
  logic respValid;
  logic [1:0] respCode;
  logic idle, csN, txStart;
  logic [7:0] txByte;
  logic txDone = 1'b0;
  logic [7:0] srcIdx;
  logic [7:0] srcData;

  logic [7:0] srcMem [PAGE_BYTES];
  logic [7:0] logByte [400];
  int logTag [400];
  int logCnt = 0;
  int riseCnt = 0;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  spi_page_writer u_spi_page_writer (.*);

  always_comb srcData = srcMem[srcIdx];

  always @(posedge csN) riseCnt++;

  // byte shifter model
  initial begin
    forever begin
      @(negedge clk);
      if (txStart) begin
        if (logCnt < 400) begin
          logByte[logCnt] = txByte;
          logTag[logCnt] = riseCnt;
        end
        logCnt++;
        repeat (2) @(negedge clk);
        txDone = 1'b1;
        @(posedge clk);
        #1 txDone = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fillSrc(input int seed);
    for (int i = 0; i < PAGE_BYTES; i++) srcMem[i] = 8'(i * 37 + seed * 11 + 5);
  endtask

  task automatic sendReq(input logic [15:0] a, input logic [7:0] n, input logic [7:0] s);
    @(negedge clk);
    reqAddr = a; reqLastIdx = n; statusIn = s; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4000 && !idle; i++) @(negedge clk);
  endtask

  task automatic checkStream(input logic [15:0] a, input int n, input int r0, input string req);
    int bad = 0;
    int act = 0;
    int exp = 0;
    int total = 2 + ADDR_BYTES + n + 1;
    check(logCnt == total, req, logCnt, total);
    for (int i = 0; i < total && i < logCnt; i++) begin
      int eb;
      int et;
      if (i == 0)      begin eb = 8'h06; et = r0; end
      else if (i == 1) begin eb = 8'h02; et = r0 + 1; end
      else if (i == 2) begin eb = a[15:8]; et = r0 + 1; end
      else if (i == 3) begin eb = a[7:0]; et = r0 + 1; end
      else             begin eb = srcMem[i-4]; et = r0 + 1; end
      if (bad == 0 && (logByte[i] != 8'(eb) || logTag[i] != et)) begin
        bad = 1; act = logByte[i]; exp = eb;
      end
    end
    check(bad == 0, {req, " byte order"}, act, exp);
    check(riseCnt == r0 + 2 && csN, {req, " frame count"}, riseCnt - r0, 2);
  endtask

  initial begin
    #(20ns * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    fillSrc(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(csN == 1'b1, "R1 csN", csN, 1);
    check(idle == 1'b1, "R1 idle", idle, 1);
    check(txStart == 1'b0 && respValid == 1'b0, "R1 strobes", txStart, 0);
    rstN = 1'b1;
    @(negedge clk);
    riseCnt = 0;

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [15:0] a = VEC[v][33:18];
      logic [7:0]  n = VEC[v][17:10];
      logic [7:0]  s = VEC[v][9:2];
      logic [1:0]  ec = VEC[v][1:0];
      int r0;
      fillSrc(v);
      logCnt = 0;
      r0 = riseCnt;
      sendReq(a, n, s);
      check(respValid == 1'b1, "R2 respValid", respValid, 1);
      check(respCode == ec, "R3/R4 respCode", respCode, ec);
      if (ec == 2'd0) begin
        waitIdle();
        checkStream(a, n, r0, (n == 8'd255) ? "R9 full page" : "R6/R7 stream");
      end else begin
        repeat (12) @(negedge clk);
        check(logCnt == 0 && riseCnt == r0, "R5 no traffic", logCnt, 0);
        check(idle == 1'b1 && csN == 1'b1, "R5 idle kept", idle, 1);
      end
    end

    // R3 request during an active write is refused; R8 stream unaffected
    begin
      int r0;
      fillSrc(40);
      logCnt = 0;
      r0 = riseCnt;
      sendReq(16'h0200, 8'd7, 8'h00);
      check(respCode == 2'd0 && idle == 1'b0, "R2 accept", respCode, 0);
      repeat (6) @(negedge clk);
      sendReq(16'h0000, 8'd0, 8'h00);
      check(respValid == 1'b1 && respCode == 2'd1, "R3 busy while active", respCode, 1);
      waitIdle();
      checkStream(16'h0200, 7, r0, "R8 stream after refused request");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule